// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may go ahead, given the outcome of a page walk that has already finished. It takes the protection bits merged across all levels of the walk (user/supervisor, writable, execute-disable), the 4-bit protection key of the leaf entry, the kind of access, the privilege of the requester, the paging control flags, the two protection-key rights registers (one for user pages, one for supervisor pages), the upper bits of the virtual address and the paging mode.

One cycle after a request it returns a verdict. The access is either allowed, raises a general-protection fault (the virtual address is not canonical in long mode), or raises a page fault with an error code built in the standard layout. A fault already reported by the walk (entry not present, or reserved bit set) overrides every permission test. After that, the tests run in a fixed order and only the first one that fails shapes the error code.

Top module: `pgperm_check`

## Requirements
- R1: A request on `reqValid` gives its verdict on the outputs at the next rising clock edge, with `rspValid` high. In a cycle after no request, `rspValid`, `allowed`, `gpFault`, `pfFault` and `errCode` are all zero. Exactly one of `allowed`, `gpFault` and `pfFault` is high whenever `rspValid` is high.
- R2: When `longMode` is set, bits 63..47 of the virtual address (bits 63..56 when `level5` is set) must all be equal. Otherwise the verdict is `gpFault` with `errCode` zero. When `longMode` is clear, the address is not checked.
- R3: `walkStat` encodes the walk result: 0 = success, 1 = not present, 2 or 3 = reserved bit set. A not-present result gives a page fault with P (bit 0) clear. A reserved-bit result gives a page fault with RSVD (bit 3) and P set. The U, W and I/D bits are formed as in R10.
- R4: A user-mode access (`userMode`=1) to a page whose combined user bit is clear is a protection fault (P set), for every access type.
- R5: `accType` encodes the access: 0 = read, 1 = write, 2 = fetch, 3 = read. A supervisor read or write to a user page faults when `ctlSmap` is set. Reads are otherwise permitted.
- R6: A write is permitted when the combined writable bit is set. It is also permitted when the access is supervisor and `ctlWp` is clear. Otherwise it is a protection fault.
- R7: A fetch faults when `protNoExec` is set and `ctlNxe` is set; `protNoExec` has no effect while `ctlNxe` is clear. A supervisor fetch from a user page faults when `ctlSmep` is set.
- R8: Key k selects bit 2k (access-disable) and bit 2k+1 (write-disable) of `pkUserReg` for user pages when `ctlPke` is set, or of `pkSupReg` for supervisor pages when `ctlPks` is set. Otherwise the rights are all zero.
- R9: Access-disable blocks reads and writes. Write-disable blocks user writes, and blocks supervisor writes when `ctlWp` is set. A key fault sets PK (bit 5) and P. Fetches never take a key fault.
- R10: In a page-fault code, U (bit 2) equals `userMode` and W (bit 1) marks a write. I/D (bit 4) marks a fetch only when `ctlNxe` or `ctlSmep` is set.
- R11: Checks are ranked as follows: canonical address, walk result, user access to supervisor page, protection key, then the read/write/fetch rules. Only the first failure is reported.
- R12: After reset and until the first request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| accType | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| userMode | input | 1 | Requester runs at user privilege |
| protUser | input | 1 | Combined user-accessible bit of the walk |
| protWrite | input | 1 | Combined writable bit of the walk |
| protNoExec | input | 1 | Combined execute-disable bit of the walk |
| pageKey | input | 4 | Protection key of the leaf entry |
| walkStat | input | 2 | Walk result: 0 ok, 1 not present, 2/3 reserved bit |
| ctlWp | input | 1 | Supervisor writes honour read-only pages |
| ctlNxe | input | 1 | Execute-disable bit is honoured |
| ctlSmep | input | 1 | Supervisor may not fetch from user pages |
| ctlSmap | input | 1 | Supervisor may not read or write user pages |
| ctlPke | input | 1 | Keys enforced on user pages |
| ctlPks | input | 1 | Keys enforced on supervisor pages |
| pkUserReg | input | 32 | Key rights for user pages |
| pkSupReg | input | 32 | Key rights for supervisor pages |
| vaHigh | input | 17 | Virtual address bits 63..47 |
| longMode | input | 1 | Long-mode paging active |
| level5 | input | 1 | Five-level paging active |
| rspValid | output | 1 | Verdict valid |
| allowed | output | 1 | Access permitted |
| gpFault | output | 1 | General-protection fault |
| pfFault | output | 1 | Page fault |
| errCode | output | 6 | Page-fault code: P0 W1 U2 RSVD3 ID4 PK5 |

## Verification
The assertions hold on every cycle. They check that each response carries exactly one verdict, that an idle cycle is silent, that a response follows each request by one cycle, and that a general-protection verdict carries no code. They also check that RSVD and PK never appear without P, and that a key fault never carries I/D. Whether the right verdict was chosen can only be shown by the bench's scenarios. These cover each permission rule under its control flags, selection of the key pair and the rights register, the canonical boundary for both paging depths, and the ranking among competing failures.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int ERR_WIDTH = 6;
  localparam int ERR_P    = 0;
  localparam int ERR_W    = 1;
  localparam int ERR_U    = 2;
  localparam int ERR_RSVD = 3;
  localparam int ERR_ID   = 4;
  localparam int ERR_PK   = 5;

  // Strobes from control to datapath: at most one verdict flag is raised.
  typedef struct packed {
    logic valid;
    logic grant;
    logic gp;
    logic notPresent;
    logic rsvd;
    logic keyDeny;
    logic protDeny;
  } verdict_t;

endpackage

// File: rtl/pgperm_ctrl.sv
module pgperm_ctrl
  import pgperm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] accType,
  input  logic       userMode,
  input  logic       protUser,
  input  logic       protWrite,
  input  logic       protNoExec,
  input  logic [1:0] walkStat,
  input  logic       ctlWp,
  input  logic       ctlNxe,
  input  logic       ctlSmep,
  input  logic       ctlSmap,
  input  logic       canonOk,
  input  logic       keyAd,
  input  logic       keyWd,
  output verdict_t   verdict
);

  logic isWrite, isFetch;
  logic userBlock, keyBlock, smapBlock, writeBlock, execBlock;

  assign isWrite = (accType == ACC_WRITE);
  assign isFetch = (accType == ACC_FETCH);

  // User request touching a supervisor page.
  assign userBlock = userMode && !protUser;

  // Protection keys never gate instruction fetches.
  assign keyBlock = !isFetch &&
                    (keyAd || (isWrite && keyWd && (userMode || ctlWp)));

  assign smapBlock  = !userMode && ctlSmap && protUser && !isFetch;
  assign writeBlock = isWrite && !protWrite && (userMode || ctlWp);
  assign execBlock  = isFetch &&
                      ((protNoExec && ctlNxe) || (!userMode && ctlSmep && protUser));

  always_comb begin
    verdict = '0;
    if (reqValid) begin
      verdict.valid = 1'b1;
      if (!canonOk) begin
        verdict.gp = 1'b1;
      end else if (walkStat == 2'd1) begin
        verdict.notPresent = 1'b1;
      end else if (walkStat[1]) begin
        verdict.rsvd = 1'b1;
      end else if (userBlock) begin
        verdict.protDeny = 1'b1;
      end else if (keyBlock) begin
        verdict.keyDeny = 1'b1;
      end else if (smapBlock || writeBlock || execBlock) begin
        verdict.protDeny = 1'b1;
      end else begin
        verdict.grant = 1'b1;
      end
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    verdict.valid |-> $onehot({verdict.grant, verdict.gp, verdict.notPresent,
                               verdict.rsvd, verdict.keyDeny, verdict.protDeny})); // R11
  AST_IDLE_NO_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    !verdict.valid |-> !(verdict.grant || verdict.gp || verdict.notPresent ||
                         verdict.rsvd || verdict.keyDeny || verdict.protDeny)); // R1
  AST_FETCH_NO_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == ACC_FETCH) |-> !verdict.keyDeny); // R9

endmodule

// File: rtl/pgperm_dp.sv
module pgperm_dp
  import pgperm_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int LA4_TOP = 47,
  parameter int LA5_TOP = 56,
  parameter int KEY_W   = 4,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int PKR_W    = 2 * NUM_KEYS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [VA_W-1:LA4_TOP]  vaHigh,
  input  logic                   longMode,
  input  logic                   level5,
  input  logic                   protUser,
  input  logic [KEY_W-1:0]       pageKey,
  input  logic                   ctlPke,
  input  logic                   ctlPks,
  input  logic                   ctlNxe,
  input  logic                   ctlSmep,
  input  logic [PKR_W-1:0]       pkUserReg,
  input  logic [PKR_W-1:0]       pkSupReg,
  input  logic [1:0]             accType,
  input  logic                   userMode,
  input  verdict_t               verdict,
  output logic                   canonOk,
  output logic                   keyAd,
  output logic                   keyWd,
  output logic                   rspValid,
  output logic                   allowed,
  output logic                   gpFault,
  output logic                   pfFault,
  output logic [ERR_WIDTH-1:0]   errCode
);

  // Canonical-address test for both paging depths.
  logic [VA_W-1:LA5_TOP] top5;
  logic ok4, ok5;
  assign top5    = vaHigh[VA_W-1:LA5_TOP];
  assign ok4     = (&vaHigh) || !(|vaHigh);
  assign ok5     = (&top5) || !(|top5);
  assign canonOk = !longMode || (level5 ? ok5 : ok4);

  // Rights register selection, then per-key pair extraction.
  logic [PKR_W-1:0]    rightsReg;
  logic [NUM_KEYS-1:0] adVec, wdVec;

  always_comb begin
    if (protUser) rightsReg = ctlPke ? pkUserReg : '0;
    else          rightsReg = ctlPks ? pkSupReg  : '0;
  end

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_keyPair
    assign adVec[k] = rightsReg[2*k];
    assign wdVec[k] = rightsReg[2*k+1];
  end

  assign keyAd = adVec[pageKey];
  assign keyWd = wdVec[pageKey];

  // Error-code assembly.
  logic anyPf;
  logic [ERR_WIDTH-1:0] codeNext;
  assign anyPf = verdict.notPresent || verdict.rsvd || verdict.keyDeny || verdict.protDeny;

  always_comb begin
    codeNext = '0;
    if (anyPf) begin
      codeNext[ERR_P]    = !verdict.notPresent;
      codeNext[ERR_W]    = (accType == ACC_WRITE);
      codeNext[ERR_U]    = userMode;
      codeNext[ERR_RSVD] = verdict.rsvd;
      codeNext[ERR_ID]   = (accType == ACC_FETCH) && (ctlNxe || ctlSmep);
      codeNext[ERR_PK]   = verdict.keyDeny;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      allowed  <= 1'b0;
      gpFault  <= 1'b0;
      pfFault  <= 1'b0;
      errCode  <= '0;
    end else begin
      rspValid <= verdict.valid;
      allowed  <= verdict.grant;
      gpFault  <= verdict.gp;
      pfFault  <= anyPf;
      errCode  <= codeNext;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    verdict.valid |=> rspValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!allowed && !gpFault && !pfFault && errCode == '0)); // R1
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({allowed, gpFault, pfFault})); // R1
  AST_GP_NO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> errCode == '0); // R2
  AST_RSVD_HAS_P: assert property (@(posedge clk) disable iff (!rstN)
    errCode[ERR_RSVD] |-> errCode[ERR_P]); // R3
  AST_PK_HAS_P: assert property (@(posedge clk) disable iff (!rstN)
    errCode[ERR_PK] |-> (errCode[ERR_P] && !errCode[ERR_ID])); // R9
  AST_CODE_ONLY_ON_PF: assert property (@(posedge clk) disable iff (!rstN)
    !pfFault |-> errCode == '0); // R10

endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
  import pgperm_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int LA4_TOP = 47,
  parameter int LA5_TOP = 56,
  parameter int KEY_W   = 4,
  localparam int PKR_W  = 2 * (1 << KEY_W)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            accType,
  input  logic                  userMode,
  input  logic                  protUser,
  input  logic                  protWrite,
  input  logic                  protNoExec,
  input  logic [KEY_W-1:0]      pageKey,
  input  logic [1:0]            walkStat,
  input  logic                  ctlWp,
  input  logic                  ctlNxe,
  input  logic                  ctlSmep,
  input  logic                  ctlSmap,
  input  logic                  ctlPke,
  input  logic                  ctlPks,
  input  logic [PKR_W-1:0]      pkUserReg,
  input  logic [PKR_W-1:0]      pkSupReg,
  input  logic [VA_W-1:LA4_TOP] vaHigh,
  input  logic                  longMode,
  input  logic                  level5,
  output logic                  rspValid,
  output logic                  allowed,
  output logic                  gpFault,
  output logic                  pfFault,
  output logic [ERR_WIDTH-1:0]  errCode
);

  verdict_t verdict;
  logic canonOk, keyAd, keyWd;

  pgperm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accType(accType),
    .userMode(userMode), .protUser(protUser), .protWrite(protWrite),
    .protNoExec(protNoExec), .walkStat(walkStat), .ctlWp(ctlWp),
    .ctlNxe(ctlNxe), .ctlSmep(ctlSmep), .ctlSmap(ctlSmap),
    .canonOk(canonOk), .keyAd(keyAd), .keyWd(keyWd), .verdict(verdict)
  );

  pgperm_dp #(
    .VA_W(VA_W), .LA4_TOP(LA4_TOP), .LA5_TOP(LA5_TOP), .KEY_W(KEY_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .vaHigh(vaHigh), .longMode(longMode),
    .level5(level5), .protUser(protUser), .pageKey(pageKey),
    .ctlPke(ctlPke), .ctlPks(ctlPks), .ctlNxe(ctlNxe), .ctlSmep(ctlSmep),
    .pkUserReg(pkUserReg), .pkSupReg(pkSupReg), .accType(accType),
    .userMode(userMode), .verdict(verdict), .canonOk(canonOk),
    .keyAd(keyAd), .keyWd(keyWd), .rspValid(rspValid), .allowed(allowed),
    .gpFault(gpFault), .pfFault(pfFault), .errCode(errCode)
  );

endmodule

// File: tb/pgperm_check_tb_top.sv
module pgperm_check_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] accType = 2'd0;
  logic userMode = 1'b0, protUser = 1'b0, protWrite = 1'b0, protNoExec = 1'b0;
  logic [3:0] pageKey = 4'd0;
  logic [1:0] walkStat = 2'd0;
  logic ctlWp = 1'b0, ctlNxe = 1'b0, ctlSmep = 1'b0, ctlSmap = 1'b0;
  logic ctlPke = 1'b0, ctlPks = 1'b0;
  logic [31:0] pkUserReg = '0, pkSupReg = '0;
  logic [63:47] vaHigh = '0;
  logic longMode = 1'b0, level5 = 1'b0;
  logic rspValid, allowed, gpFault, pfFault;
  logic [5:0] errCode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pgperm_check dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accType(accType),
    .userMode(userMode), .protUser(protUser), .protWrite(protWrite),
    .protNoExec(protNoExec), .pageKey(pageKey), .walkStat(walkStat),
    .ctlWp(ctlWp), .ctlNxe(ctlNxe), .ctlSmep(ctlSmep), .ctlSmap(ctlSmap),
    .ctlPke(ctlPke), .ctlPks(ctlPks), .pkUserReg(pkUserReg),
    .pkSupReg(pkSupReg), .vaHigh(vaHigh), .longMode(longMode),
    .level5(level5), .rspValid(rspValid), .allowed(allowed),
    .gpFault(gpFault), .pfFault(pfFault), .errCode(errCode)
  );

  // Compare the full response against the expectation.
  task automatic expect_rsp(input string tag, input bit expV, input bit expA,
                            input bit expG, input bit expP, input logic [5:0] expC);
    checks++;
    if (rspValid !== expV || allowed !== expA || gpFault !== expG ||
        pfFault !== expP || errCode !== expC) begin
      fails++;
      $display("FAIL %s: got v=%b a=%b gp=%b pf=%b code=%02h, expected v=%b a=%b gp=%b pf=%b code=%02h",
               tag, rspValid, allowed, gpFault, pfFault, errCode,
               expV, expA, expG, expP, expC);
    end
  endtask

  task automatic clear_inputs();
    accType = 2'd0; userMode = 0; protUser = 0; protWrite = 0; protNoExec = 0;
    pageKey = 0; walkStat = 0; ctlWp = 0; ctlNxe = 0; ctlSmep = 0; ctlSmap = 0;
    ctlPke = 0; ctlPks = 0; pkUserReg = '0; pkSupReg = '0; vaHigh = '0;
    longMode = 0; level5 = 0;
  endtask

  // Issue one request at a falling edge; the verdict is registered at the
  // following rising edge and sampled at the next falling edge.
  task automatic fire();
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic grant(input string tag);
    fire();
    expect_rsp(tag, 1, 1, 0, 0, 6'h00);
  endtask

  task automatic page_fault(input string tag, input logic [5:0] code);
    fire();
    expect_rsp(tag, 1, 0, 0, 1, code);
  endtask

  task automatic test_reset_and_idle();
    expect_rsp("R12 reset state", 0, 0, 0, 0, 6'h00);
    clear_inputs();
    grant("R1 supervisor read granted");
    @(negedge clk);
    expect_rsp("R1 idle after request", 0, 0, 0, 0, 6'h00);
  endtask

  task automatic test_user_super();
    clear_inputs(); userMode = 1; protUser = 0;
    page_fault("R4 user read of supervisor page", 6'h05);
    accType = 2'd2;
    page_fault("R4 R10 user fetch supervisor page no ID", 6'h05);
  endtask

  task automatic test_smap();
    clear_inputs(); protUser = 1; ctlSmap = 1;
    page_fault("R5 supervisor read user page restricted", 6'h01);
    accType = 2'd1; protWrite = 1;
    page_fault("R5 supervisor write user page restricted", 6'h03);
    ctlSmap = 0;
    grant("R5 restriction off");
    ctlSmap = 1; userMode = 1; accType = 2'd3;
    grant("R5 user read of user page");
  endtask

  task automatic test_write();
    clear_inputs(); accType = 2'd1; protWrite = 0;
    grant("R6 supervisor write read-only WP clear");
    ctlWp = 1;
    page_fault("R6 supervisor write read-only WP set", 6'h03);
    userMode = 1; protUser = 1; ctlWp = 0;
    page_fault("R6 R10 user write read-only", 6'h07);
  endtask

  task automatic test_fetch();
    clear_inputs(); accType = 2'd2; protNoExec = 1; ctlNxe = 1;
    page_fault("R7 R10 fetch from no-exec page", 6'h11);
    ctlNxe = 0;
    grant("R7 no-exec ignored when NXE clear");
    protNoExec = 0; protUser = 1; ctlSmep = 1;
    page_fault("R7 supervisor fetch user page SMEP", 6'h11);
    userMode = 1;
    grant("R7 user fetch user page with SMEP");
  endtask

  task automatic test_keys();
    clear_inputs(); userMode = 1; protUser = 1; pageKey = 4'd3;
    pkUserReg = 32'h0000_0040; ctlPke = 1;
    page_fault("R8 R9 user key access-disable", 6'h25);
    pageKey = 4'd4;
    grant("R8 other key pair unaffected");
    pageKey = 4'd3; ctlPke = 0;
    grant("R8 PKE clear reads zero");
    ctlPke = 1; accType = 2'd2;
    grant("R9 fetch never key fault");
    clear_inputs(); pageKey = 4'd2; pkSupReg = 32'h0000_0020; ctlPks = 1;
    accType = 2'd1; protWrite = 1;
    grant("R9 supervisor write-disable WP clear");
    ctlWp = 1;
    page_fault("R9 supervisor write-disable WP set", 6'h23);
    pkUserReg = 32'hFFFF_FFFF; ctlPke = 1;
    page_fault("R8 supervisor page uses supervisor rights", 6'h23);
    clear_inputs(); userMode = 1; protUser = 1; protWrite = 1; accType = 2'd1;
    pageKey = 4'd1; pkUserReg = 32'h0000_0008; ctlPke = 1;
    page_fault("R9 user write-disable", 6'h27);
  endtask

  task automatic test_walk();
    clear_inputs(); walkStat = 2'd1; userMode = 1; protUser = 1; accType = 2'd1;
    page_fault("R3 not-present user write", 6'h06);
    clear_inputs(); walkStat = 2'd2;
    page_fault("R3 reserved-bit read", 6'h09);
    walkStat = 2'd3; accType = 2'd2; ctlNxe = 1;
    page_fault("R3 R10 reserved-bit fetch", 6'h19);
    walkStat = 2'd1;
    page_fault("R3 not-present fetch", 6'h10);
  endtask

  task automatic test_canonical();
    clear_inputs(); longMode = 1; vaHigh = 17'h00001;
    fire();
    expect_rsp("R2 bit 47 set upper clear", 1, 0, 1, 0, 6'h00);
    level5 = 1;
    grant("R2 five-level accepts same address");
    vaHigh = 17'h0FFFF;
    fire();
    expect_rsp("R2 five-level bit 56 mismatch", 1, 0, 1, 0, 6'h00);
    level5 = 0; vaHigh = 17'h1FFFF;
    grant("R2 all ones canonical");
    longMode = 0; vaHigh = 17'h00001;
    grant("R2 no check outside long mode");
  endtask

  task automatic test_priority();
    clear_inputs(); longMode = 1; vaHigh = 17'h00100; walkStat = 2'd1;
    fire();
    expect_rsp("R11 canonical beats walk fault", 1, 0, 1, 0, 6'h00);
    clear_inputs(); walkStat = 2'd1; userMode = 1; protUser = 0;
    page_fault("R11 walk fault beats user check", 6'h04);
    clear_inputs(); userMode = 1; protUser = 0; pkSupReg = 32'h1; ctlPks = 1;
    page_fault("R11 user check beats key", 6'h05);
    clear_inputs(); userMode = 1; protUser = 1; accType = 2'd1; protWrite = 0;
    pkUserReg = 32'h1; ctlPke = 1;
    page_fault("R11 key beats write rule", 6'h27);
  endtask

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    expect_rsp("R12 outputs during reset", 0, 0, 0, 0, 6'h00);
    rstN = 1'b1;
    @(negedge clk);
    test_reset_and_idle();
    test_user_super();
    test_smap();
    test_write();
    test_fetch();
    test_keys();
    test_walk();
    test_canonical();
    test_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule